// File: doc/BRIEF.md
# Trigger Pipeline with Level-2 Capture Buffers

This block keeps a wide bus of deserialized hit samples in a circular pipeline memory that is written on every clock. A first-level accept (L1A) starts a capture: a programmable number of consecutive samples is copied into one of several Level-2 buffers. The captured samples are those that arrived a programmable number of cycles before the accept. Write and read addresses of the pipeline come from one wrapping counter. The read address trails the write address by the latency register, so the trigger latency is a single subtraction.

The buffers fill independently from the same delayed sample stream. An accept may therefore arrive on every clock edge while buffers remain free, and captures overlap without interfering. A second-level accept (L2A) names one buffer. The block copies that buffer's words into a separate readout memory, which frees the buffer for a new L1A. A busy flag covers the copy, a done pulse marks its end, and the readout memory is read through a simple address/data port.

Top module: `trig_l2_pipe`

## Requirements
- R1: For an L1A sampled at clock edge c with latency register value L, captured word k holds the sample presented at edge c-L+k. L is written through `lat_we_i`; the allowed range is 1 to PIPE_DEPTH-1, and writing 0 stores 1.
- R2: The capture length register N sets how many words each capture takes and each copy moves. Writing 0 stores 1, and writing a value above BUF_DEPTH stores BUF_DEPTH. The length in force at the L1A edge applies to that capture.
- R3: Accepted L1As go to buffers in round-robin order, starting at buffer 0 after reset. Bit b of `buf_full_o` is high from the edge that writes buffer b's last word until the edge at which an L2A for buffer b is accepted.
- R4: An L1A whose turn falls on a buffer that is not free is dropped, and the rotation does not advance. `l1a_ovf_o` is high for exactly the one cycle that follows that edge.
- R5: L1As on consecutive edges are all accepted while the buffers in turn are free. Their captures overlap in time and each holds its own window.
- R6: An L2A is accepted when the copier is idle and the selected buffer is full. `cp_busy_o` is then high for N cycles, and `cp_done_o` pulses for one cycle at the same edge where busy falls. Readout words 0 to N-1 then hold the buffer's words.
- R7: An L2A is ignored when the copier is busy or the selected buffer is free, filling or already draining. In that case busy stays unchanged and the readout memory is untouched.
- R8: A buffer becomes free at the edge where its copy completes, and it can take an L1A from the next edge on.
- R9: `rd_data_o` returns readout word `rd_addr_i` one clock after the address is presented. It shows the value held before any copy write at that same edge.
- R10: After reset, `buf_full_o`, `cp_busy_o`, `cp_done_o` and `l1a_ovf_o` are low. The latency register holds LAT_RST and the length register holds LEN_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | SAMPLE_W | Deserialized sample bus, one word per clock |
| l1a_i | input | 1 | First-level accept strobe |
| l2a_i | input | 1 | Second-level accept strobe |
| l2a_sel_i | input | log2(NBUF) | Buffer named by the L2A |
| lat_we_i | input | 1 | Latency register write enable |
| lat_wdata_i | input | log2(PIPE_DEPTH) | Latency value in clocks |
| len_we_i | input | 1 | Capture length register write enable |
| len_wdata_i | input | log2(BUF_DEPTH)+1 | Capture length in words |
| rd_addr_i | input | log2(BUF_DEPTH) | Readout memory word address |
| rd_data_o | output | SAMPLE_W | Readout memory data, one cycle after address |
| buf_full_o | output | NBUF | Per-buffer captured-and-unread flags |
| cp_busy_o | output | 1 | Copy into readout memory in progress |
| cp_done_o | output | 1 | One-cycle pulse at copy completion |
| l1a_ovf_o | output | 1 | One-cycle pulse after a dropped L1A |

## Verification
The assertions assume the latency and length registers are not written while a capture is filling. They also assume the pipeline has run for at least the latency before the first L1A, so that every delayed read hits a written entry. The stimulus writes configuration only while all buffers are idle, and idles well beyond PIPE_DEPTH cycles after reset before the first accept. Every L2A selector lies in range because NBUF is a power of two, so the stimulus can aim accepts at full, filling, draining and free buffers. This lets the bench exercise both the accepted and the ignored paths.

// File: rtl/trig_l2_pkg.sv
package trig_l2_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_FILL  = 2'd1,
      SLOT_FULL  = 2'd2,
      SLOT_DRAIN = 2'd3
   } slot_st_e;
endpackage

// File: rtl/trig_l2_ptr.sv
module trig_l2_ptr #(
   parameter int AW      = 9,
   parameter int LAT_RST = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          lat_we_i,
   input  logic [AW-1:0] lat_wdata_i,
   output logic [AW-1:0] wr_addr_o,
   output logic [AW-1:0] rd_addr_o
);
   logic [AW-1:0] wr_q;
   logic [AW-1:0] lat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_q  <= '0;
         lat_q <= AW'(LAT_RST);
      end else begin
         wr_q <= wr_q + 1'b1;
         if (lat_we_i)
            lat_q <= (lat_wdata_i == '0) ? AW'(1) : lat_wdata_i;
      end
   end

   assign wr_addr_o = wr_q;
   assign rd_addr_o = wr_q - lat_q;

   // R1: the shared counter steps by one each clock, wrapping
   a_r1_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> wr_q == AW'($past(wr_q) + 1'b1));
   // R1: read address never equals write address
   a_r1_ptr_sep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_addr_o != wr_addr_o);
endmodule

// File: rtl/trig_l2_pipe_ram.sv
module trig_l2_pipe_ram #(
   parameter int W     = 480,
   parameter int DEPTH = 512,
   parameter int AW    = 9
) (
   input  logic          clk_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [W-1:0]  din_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [W-1:0]  dout_o
);
   logic [W-1:0] mem [DEPTH];
   logic [W-1:0] q;

   always_ff @(posedge clk_i) begin
      mem[wr_addr_i] <= din_i;
      q              <= mem[rd_addr_i];
   end

   assign dout_o = q;
endmodule

// File: rtl/trig_l2_slot.sv
module trig_l2_slot
   import trig_l2_pkg::*;
#(
   parameter int W     = 480,
   parameter int DEPTH = 32,
   parameter int BAW   = 5,
   parameter int LW    = 6
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           start_i,
   input  logic [LW-1:0]  len_i,
   input  logic [W-1:0]   din_i,
   input  logic           drain_i,
   input  logic           release_i,
   input  logic [BAW-1:0] rd_idx_i,
   output logic [W-1:0]   rd_data_o,
   output logic           free_o,
   output logic           full_o,
   output logic [LW-1:0]  len_o
);
   slot_st_e       st_q;
   logic [BAW-1:0] cnt_q;
   logic [LW-1:0]  len_q;
   logic           last;
   logic [W-1:0]   mem [DEPTH];

   assign last = ({1'b0, cnt_q} == len_q - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= SLOT_FREE;
         cnt_q <= '0;
         len_q <= LW'(1);
      end else begin
         unique case (st_q)
            SLOT_FREE: if (start_i) begin
               st_q  <= SLOT_FILL;
               cnt_q <= '0;
               len_q <= len_i;
            end
            SLOT_FILL: begin
               cnt_q <= cnt_q + 1'b1;
               if (last) st_q <= SLOT_FULL;
            end
            SLOT_FULL:  if (drain_i)   st_q <= SLOT_DRAIN;
            SLOT_DRAIN: if (release_i) st_q <= SLOT_FREE;
            default:    st_q <= SLOT_FREE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (st_q == SLOT_FILL) mem[cnt_q] <= din_i;
   end

   assign rd_data_o = mem[rd_idx_i];
   assign free_o    = (st_q == SLOT_FREE);
   assign full_o    = (st_q == SLOT_FULL);
   assign len_o     = len_q;

   // R3: a capture is only started on a free buffer
   a_r3_start_on_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> st_q == SLOT_FREE);
   // R5: the fill index stays inside the latched length
   a_r5_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_q == SLOT_FILL |-> {1'b0, cnt_q} < len_q);
   // R8: release only comes to a draining buffer
   a_r8_release_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      release_i |-> st_q == SLOT_DRAIN);
   // R6: drain only hits a full buffer
   a_r6_drain_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drain_i |-> st_q == SLOT_FULL);
endmodule

// File: rtl/trig_l2_copy.sv
module trig_l2_copy #(
   parameter int W      = 480,
   parameter int DEPTH  = 32,
   parameter int NBUF   = 4,
   parameter int SW     = 2,
   parameter int BAW    = 5,
   parameter int LW     = 6,
   parameter bit RD_REG = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            l2a_i,
   input  logic [SW-1:0]   l2a_sel_i,
   input  logic [NBUF-1:0] full_i,
   input  logic [LW-1:0]   len_i [NBUF],
   input  logic [W-1:0]    din_i,
   output logic [NBUF-1:0] drain_o,
   output logic [NBUF-1:0] release_o,
   output logic [SW-1:0]   src_sel_o,
   output logic [BAW-1:0]  src_idx_o,
   output logic            busy_o,
   output logic            done_o,
   input  logic [BAW-1:0]  rd_addr_i,
   output logic [W-1:0]    rd_data_o
);
   logic           busy_q, done_q, accept, last;
   logic [SW-1:0]  sel_q;
   logic [BAW-1:0] idx_q;
   logic [LW-1:0]  len_q;
   logic [W-1:0]   ro_mem [DEPTH];

   assign accept    = l2a_i && !busy_q && full_i[l2a_sel_i];
   assign last      = busy_q && ({1'b0, idx_q} == len_q - 1'b1);
   assign drain_o   = accept ? (NBUF'(1) << l2a_sel_i) : '0;
   assign release_o = last ? (NBUF'(1) << sel_q) : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         sel_q  <= '0;
         idx_q  <= '0;
         len_q  <= LW'(1);
      end else begin
         done_q <= last;
         if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            sel_q  <= l2a_sel_i;
            len_q  <= len_i[l2a_sel_i];
         end else if (busy_q) begin
            idx_q <= idx_q + 1'b1;
            if (last) busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (busy_q) ro_mem[idx_q] <= din_i;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [W-1:0] rd_q;
         always_ff @(posedge clk_i) rd_q <= ro_mem[rd_addr_i];
         assign rd_data_o = rd_q;
      end else begin : g_rd_comb
         assign rd_data_o = ro_mem[rd_addr_i];
      end
   endgenerate

   assign src_sel_o = sel_q;
   assign src_idx_o = idx_q;
   assign busy_o    = busy_q;
   assign done_o    = done_q;

   // R6: done pulses exactly where busy has just fallen
   a_r6_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> !busy_q && $past(busy_q));
   // R7: a copy starts only from an accept on a full buffer
   a_r7_start_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> $past(l2a_i && full_i[l2a_sel_i]));
   // R6: done never repeats on consecutive cycles
   a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);
endmodule

// File: rtl/trig_l2_pipe.sv
module trig_l2_pipe #(
   parameter int SAMPLE_W   = 480,
   parameter int PIPE_DEPTH = 512,
   parameter int BUF_DEPTH  = 32,
   parameter int NBUF       = 4,
   parameter int LAT_RST    = 8,
   parameter int LEN_RST    = 16,
   parameter bit RD_REG     = 1'b1,
   localparam int AW = $clog2(PIPE_DEPTH),
   localparam int BAW = $clog2(BUF_DEPTH),
   localparam int LW = BAW + 1,
   localparam int SW = $clog2(NBUF)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic                l1a_i,
   input  logic                l2a_i,
   input  logic [SW-1:0]       l2a_sel_i,
   input  logic                lat_we_i,
   input  logic [AW-1:0]       lat_wdata_i,
   input  logic                len_we_i,
   input  logic [LW-1:0]       len_wdata_i,
   input  logic [BAW-1:0]      rd_addr_i,
   output logic [SAMPLE_W-1:0] rd_data_o,
   output logic [NBUF-1:0]     buf_full_o,
   output logic                cp_busy_o,
   output logic                cp_done_o,
   output logic                l1a_ovf_o
);
   generate
      if ((PIPE_DEPTH & (PIPE_DEPTH - 1)) != 0 || PIPE_DEPTH < 4) begin : g_bad_pipe
         $error("PIPE_DEPTH must be a power of two of at least 4");
      end
      if ((BUF_DEPTH & (BUF_DEPTH - 1)) != 0 || BUF_DEPTH < 2) begin : g_bad_buf
         $error("BUF_DEPTH must be a power of two of at least 2");
      end
      if ((NBUF & (NBUF - 1)) != 0 || NBUF < 2) begin : g_bad_nbuf
         $error("NBUF must be a power of two of at least 2");
      end
      if (LAT_RST < 1 || LAT_RST >= PIPE_DEPTH) begin : g_bad_lat
         $error("LAT_RST out of range");
      end
      if (LEN_RST < 1 || LEN_RST > BUF_DEPTH) begin : g_bad_len
         $error("LEN_RST out of range");
      end
   endgenerate

   logic [AW-1:0]       wr_addr, rd_addr;
   logic [SAMPLE_W-1:0] dly_smp;
   logic [LW-1:0]       len_q;
   logic [SW-1:0]       rr_q;
   logic                ovf_q;
   logic [NBUF-1:0]     slot_free, slot_full, slot_start, slot_drain, slot_rel;
   logic [LW-1:0]       slot_len [NBUF];
   logic [SAMPLE_W-1:0] slot_rd  [NBUF];
   logic [SW-1:0]       cp_sel;
   logic [BAW-1:0]      cp_idx;

   trig_l2_ptr #(.AW(AW), .LAT_RST(LAT_RST)) u_ptr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lat_we_i    (lat_we_i),
      .lat_wdata_i (lat_wdata_i),
      .wr_addr_o   (wr_addr),
      .rd_addr_o   (rd_addr)
   );

   trig_l2_pipe_ram #(.W(SAMPLE_W), .DEPTH(PIPE_DEPTH), .AW(AW)) u_ram (
      .clk_i     (clk_i),
      .wr_addr_i (wr_addr),
      .din_i     (smp_i),
      .rd_addr_i (rd_addr),
      .dout_o    (dly_smp)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_q <= LW'(LEN_RST);
         rr_q  <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (len_we_i) begin
            if (len_wdata_i == '0)               len_q <= LW'(1);
            else if (len_wdata_i > LW'(BUF_DEPTH)) len_q <= LW'(BUF_DEPTH);
            else                                  len_q <= len_wdata_i;
         end
         ovf_q <= l1a_i && !slot_free[rr_q];
         if (l1a_i && slot_free[rr_q]) rr_q <= rr_q + 1'b1;
      end
   end

   assign slot_start = (l1a_i && slot_free[rr_q]) ? (NBUF'(1) << rr_q) : '0;

   generate
      for (genvar b = 0; b < NBUF; b++) begin : g_slot
         trig_l2_slot #(.W(SAMPLE_W), .DEPTH(BUF_DEPTH), .BAW(BAW), .LW(LW)) u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .start_i   (slot_start[b]),
            .len_i     (len_q),
            .din_i     (dly_smp),
            .drain_i   (slot_drain[b]),
            .release_i (slot_rel[b]),
            .rd_idx_i  (cp_idx),
            .rd_data_o (slot_rd[b]),
            .free_o    (slot_free[b]),
            .full_o    (slot_full[b]),
            .len_o     (slot_len[b])
         );
      end
   endgenerate

   trig_l2_copy #(
      .W(SAMPLE_W), .DEPTH(BUF_DEPTH), .NBUF(NBUF), .SW(SW),
      .BAW(BAW), .LW(LW), .RD_REG(RD_REG)
   ) u_copy (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .l2a_i     (l2a_i),
      .l2a_sel_i (l2a_sel_i),
      .full_i    (slot_full),
      .len_i     (slot_len),
      .din_i     (slot_rd[cp_sel]),
      .drain_o   (slot_drain),
      .release_o (slot_rel),
      .src_sel_o (cp_sel),
      .src_idx_o (cp_idx),
      .busy_o    (cp_busy_o),
      .done_o    (cp_done_o),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

   assign buf_full_o = slot_full;
   assign l1a_ovf_o  = ovf_q;

   // R4: an overflow pulse always follows an L1A
   a_r4_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_q |-> $past(l1a_i));
   // R3: at most one buffer starts per edge
   a_r3_one_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(slot_start));
   // R8: the copier releases at most one buffer per edge
   a_r8_one_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(slot_rel));
endmodule

// File: tb/trig_l2_pipe_tb.sv
module trig_l2_pipe_tb;
   localparam int W = 12;
   localparam int PD = 64;
   localparam int BD = 8;
   localparam int NB = 4;
   localparam int LATR = 3;
   localparam int LENR = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [W-1:0]  smp = '0;
   logic          l1a = 1'b0, l2a = 1'b0, lat_we = 1'b0, len_we = 1'b0;
   logic [1:0]    l2a_sel = '0;
   logic [5:0]    lat_wd = '0;
   logic [3:0]    len_wd = '0;
   logic [2:0]    rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic [NB-1:0] buf_full;
   logic          busy, done, ovf;

   trig_l2_pipe #(
      .SAMPLE_W(W), .PIPE_DEPTH(PD), .BUF_DEPTH(BD), .NBUF(NB),
      .LAT_RST(LATR), .LEN_RST(LENR), .RD_REG(1'b1)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .l1a_i(l1a), .l2a_i(l2a),
      .l2a_sel_i(l2a_sel), .lat_we_i(lat_we), .lat_wdata_i(lat_wd),
      .len_we_i(len_we), .len_wdata_i(len_wd), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .buf_full_o(buf_full), .cp_busy_o(busy),
      .cp_done_o(done), .l1a_ovf_o(ovf)
   );

   always #10 clk = ~clk;

   // reference model state
   int n_cmp = 0, n_bad = 0, cyc = 0, smp_cnt = 0;
   bit seen = 1'b0, finished = 1'b0;
   logic [W-1:0] hist [int];
   int m_lat = LATR, m_len = LENR, rr = 0;
   int st [NB], fcnt [NB], flen [NB], fbase [NB];
   bit m_busy = 1'b0, m_done = 1'b0, m_ovf = 1'b0;
   int csel = 0, cidx = 0, clen = 0;
   logic [W-1:0] ro [BD];
   bit rov [BD];
   logic [W-1:0] rdexp = '0;
   bit rdv = 1'b0;

   always @(negedge clk) begin
      smp = W'(smp_cnt * 37 + 11);
      smp_cnt++;
   end

   always @(posedge clk) begin
      int p_st [NB];
      bit p_busy;
      seen = 1'b1;
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin st[b] = 0; fcnt[b] = 0; flen[b] = 0; fbase[b] = 0; end
         for (int i = 0; i < BD; i++) rov[i] = 1'b0;
         m_busy = 0; m_done = 0; m_ovf = 0; rr = 0; rdv = 0;
         m_lat = LATR; m_len = LENR;
      end else begin
         p_st = st;
         p_busy = m_busy;
         hist[cyc] = smp;
         rdv = rov[rd_addr];
         rdexp = ro[rd_addr];
         for (int b = 0; b < NB; b++)
            if (p_st[b] == 1) begin
               fcnt[b]++;
               if (fcnt[b] == flen[b]) st[b] = 2;
            end
         m_done = 1'b0;
         if (p_busy) begin
            ro[cidx] = hist[fbase[csel] + cidx];
            rov[cidx] = 1'b1;
            cidx++;
            if (cidx == clen) begin m_busy = 0; m_done = 1; st[csel] = 0; end
         end
         if (l2a && !p_busy && p_st[l2a_sel] == 2) begin
            m_busy = 1; csel = int'(l2a_sel); cidx = 0; clen = flen[l2a_sel]; st[l2a_sel] = 3;
         end
         m_ovf = 1'b0;
         if (l1a) begin
            if (p_st[rr] == 0) begin
               st[rr] = 1; fcnt[rr] = 0; flen[rr] = m_len; fbase[rr] = cyc - m_lat;
               rr = (rr + 1) % NB;
            end else m_ovf = 1'b1;
         end
         if (lat_we) m_lat = (lat_wd == 0) ? 1 : int'(lat_wd);
         if (len_we) m_len = (len_wd == 0) ? 1 : (len_wd > BD) ? BD : int'(len_wd);
         cyc++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (seen && !finished) begin
         chk("R6 R7 R10 cp_busy", 32'(busy), 32'(m_busy));
         chk("R6 R10 cp_done", 32'(done), 32'(m_done));
         chk("R4 R10 l1a_ovf", 32'(ovf), 32'(m_ovf));
         begin
            logic [NB-1:0] ef;
            for (int b = 0; b < NB; b++) ef[b] = (st[b] == 2);
            chk("R3 R5 R8 R10 buf_full", 32'(buf_full), 32'(ef));
         end
         if (rdv) chk("R1 R2 R9 readout", 32'(rd_data), 32'(rdexp));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic do_l1a(input int n);
      @(negedge clk); l1a = 1'b1;
      step(n);
      l1a = 1'b0;
   endtask
   task automatic do_l2a(input int s);
      @(negedge clk); l2a = 1'b1; l2a_sel = 2'(s);
      @(negedge clk); l2a = 1'b0;
   endtask
   task automatic set_cfg(input int lat, input int len);
      @(negedge clk); lat_we = 1'b1; len_we = 1'b1; lat_wd = 6'(lat); len_wd = 4'(len);
      @(negedge clk); lat_we = 1'b0; len_we = 1'b0;
   endtask
   task automatic sweep();
      for (int i = 0; i < BD; i++) begin @(negedge clk); rd_addr = 3'(i); end
      step(2);
   endtask
   task automatic summary();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      step(4);
      rst_n = 1'b1;
      step(80);
      // R10 reset register values, R1 latency, R6 copy
      do_l1a(1); step(8);
      do_l2a(0); step(8); sweep();
      // R5 back-to-back, R4 overflow on fifth accept
      do_l1a(5); step(8);
      // R6 copy of buffer 2, R7 L2A while busy is ignored
      do_l2a(2); do_l2a(3); step(8); sweep();
      do_l2a(2); step(2);            // R7 buffer already free
      do_l2a(3); step(8); sweep();
      do_l2a(0); step(8);
      do_l2a(1); step(8); sweep();
      // R2 length 0 -> 1, R1 latency 0 -> 1, R8 reuse after release
      set_cfg(0, 0); step(2);
      do_l1a(1); step(4);
      do_l2a(1); step(4); sweep();
      // R2 length clamp to depth, R1 long latency, R7 L2A while filling
      set_cfg(40, 15); step(2);
      do_l1a(2); do_l2a(3); step(12);
      do_l2a(3); step(10); sweep();
      do_l2a(2); step(10); sweep();
      // R8 drained buffers accept again
      set_cfg(7, 5); step(2);
      do_l1a(4); step(8);
      do_l2a(0); step(7); do_l2a(1); step(7); sweep();
      do_l2a(2); step(7); do_l2a(3); step(7); sweep();
      summary();
   end
endmodule